// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Level and Character Timeout

This block holds the bytes a serial receiver has assembled until the host reads them. In queued mode it is a 16-entry circular buffer with a head pointer, a tail pointer and an occupancy count. In single-byte mode it keeps exactly one held byte. A control register selects the mode and the interrupt trigger level, and its self-clearing bits empty the receive queue and tell the transmit side to empty its own queue. The host reads the control register back through `ctl_value`.

Every accepted byte, and every read that leaves bytes behind, restarts a watchdog of four character times. The length of one character time is given in clock cycles on `char_time`. If the watchdog runs out while bytes are still waiting, a timeout-pending flag is raised, and the next host read clears it. A break condition from the receiver is stored as a zero byte and marked with a break status bit.

Interrupt encoding and serial deserialisation belong to neighbouring blocks. They use `count`, `trig_level`, `data_ready`, `break_flag` and `timeout_pend` to decide what to raise.

Top module: `rxq_buffer`

## Requirements
- R1: In queued mode, up to 16 bytes are returned in arrival order. `count` gives the occupancy, and `data_ready` is 1 exactly when `count` is nonzero. After reset, `count`, `data_ready`, `break_flag`, `timeout_pend`, `overrun` and `ctl_value` are all 0.
- R2: A control write that changes the register stores only bits 7, 6, 3 and 0 of the written value (mask 0xC9). Bit 0 selects queued mode (1) or single-byte mode (0).
- R3: `trig_level` decodes control bits 7:6 as 00→1, 01→4, 10→8 and 11→14. It updates only on an accepted write that has bit 0 set, and it is 1 after reset.
- R4: An accepted write with bit 1 set empties the receive queue. It clears `count`, `data_ready`, `break_flag` and `timeout_pend`, and it discards any push or pop in that cycle. An accepted write with bit 2 set makes `tx_flush` high for the one cycle after the write.
- R5: An accepted write that changes bit 0 acts as if bits 1 and 2 were both set: both queues are flushed.
- R6: A write equal to the stored value has no effect: no flush, no `tx_flush` pulse, and the stored value and trigger level are unchanged.
- R7: In queued mode, `timeout_pend` rises exactly 4×`char_time` clock edges after the last accepted push, or after the last read that left bytes behind, if `count` is then nonzero. It never rises in single-byte mode or with an empty queue.
- R8: Any host read in queued mode clears `timeout_pend`.
- R9: A break from the receiver stores the byte 0x00 and sets `break_flag` and `data_ready`. `break_flag` clears when a read leaves `count` at 0.
- R10: A read of an empty queue in queued mode returns 0x00 and leaves `count` at 0.
- R11: A push into a full queue is dropped, and `overrun` is high for one cycle. A pop in the same cycle makes room, so the push is then accepted.
- R12: In single-byte mode `count` is 0 or 1. A read returns the held byte and clears `data_ready` and `break_flag`. A push while a byte is held is dropped and raises `overrun`.
- R13: The byte removed by a `pop` appears on `rd_data` in the cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Receiver delivers `push_data` |
| push_data | input | 8 | Received byte |
| push_break | input | 1 | Receiver reports a break; stores 0x00 |
| pop | input | 1 | Host read of the data register |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| char_time | input | 12 | One character time in clock cycles |
| rd_data | output | 8 | Byte returned by the last pop |
| count | output | 5 | Bytes held |
| data_ready | output | 1 | At least one byte held |
| break_flag | output | 1 | Break byte received and not yet drained |
| trig_level | output | 5 | Selected trigger level in bytes |
| ctl_value | output | 8 | Stored control register |
| tx_flush | output | 1 | One-cycle request to empty the transmit queue |
| timeout_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | One-cycle pulse when a push is dropped |

## Verification
Two kinds of event collide in the same cycle, and the bench provokes each collision on purpose. First, a push and a pop land on the same edge while the queue is full. The bench judges this by `count` staying at 16, `overrun` staying low and the pushed byte coming out last during the drain. Second, a host read restarts the timeout while bytes remain. The bench counts edges after that read and expects `timeout_pend` low one edge before 4×`char_time` and high exactly at it. A further contest is a control write that flushes while a timeout is pending: the bench checks that the flag and the count are both clear on the next sample.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CTL_KEEP_MASK = 8'hC9;
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_RXCLR_BIT = 1;
  localparam int CTL_TXCLR_BIT = 2;

  function automatic int unsigned trig_decode(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_q,
  output logic [CNT_W-1:0] trig_q,
  output logic             rx_clr,
  output logic             tx_flush_q
);
  import rxq_pkg::*;

  logic accept_wr, en_toggle, tx_clr;

  always_comb begin
    accept_wr = ctl_we && (ctl_wdata != ctl_q);
    en_toggle = ctl_wdata[CTL_EN_BIT] ^ ctl_q[CTL_EN_BIT];
    rx_clr    = accept_wr && (ctl_wdata[CTL_RXCLR_BIT] || en_toggle);
    tx_clr    = accept_wr && (ctl_wdata[CTL_TXCLR_BIT] || en_toggle);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      trig_q     <= CNT_W'(1);
      tx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= tx_clr;
      if (accept_wr) begin
        ctl_q <= ctl_wdata & 8'(CTL_KEEP_MASK);
        if (ctl_wdata[CTL_EN_BIT])
          trig_q <= CNT_W'(trig_decode(ctl_wdata[7:6]));
      end
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_on,
  input  logic             flush,
  input  logic             push_valid,
  input  logic [DW-1:0]    push_data,
  input  logic             push_break,
  input  logic             pop,
  output logic [DW-1:0]    rd_data,
  output logic [CNT_W-1:0] count,
  output logic             data_ready,
  output logic             break_flag,
  output logic             overrun,
  output logic             accept,
  output logic             pop_left
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] head, tail;
  logic [DW-1:0]    hold;
  logic [DW-1:0]    in_byte;
  logic [CNT_W-1:0] count_nx;
  logic             push_req, at_cap, pop_eff;

  always_comb begin
    push_req = push_valid || push_break;
    in_byte  = push_break ? '0 : push_data;
    at_cap   = fifo_on ? (count == CNT_W'(DEPTH)) : (count != '0);
    pop_eff  = pop && (count != '0) && !flush;
    accept   = push_req && !flush && (!at_cap || pop_eff);
    count_nx = count;
    if (accept)  count_nx = count_nx + CNT_W'(1);
    if (pop_eff) count_nx = count_nx - CNT_W'(1);
    if (flush)   count_nx = '0;
    pop_left = pop_eff && (count_nx != '0);
  end

  always_ff @(posedge clk) begin
    if (accept && fifo_on) mem[head] <= in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head       <= '0;
      tail       <= '0;
      hold       <= '0;
      count      <= '0;
      data_ready <= 1'b0;
      break_flag <= 1'b0;
      overrun    <= 1'b0;
      rd_data    <= '0;
    end else begin
      overrun <= push_req && !accept;
      if (pop) begin
        if (!fifo_on)     rd_data <= hold;
        else if (pop_eff) rd_data <= mem[tail];
        else              rd_data <= '0;
      end
      if (pop_eff && fifo_on)
        tail <= (tail == PTR_W'(DEPTH - 1)) ? '0 : tail + PTR_W'(1);
      if (accept) begin
        if (fifo_on) head <= (head == PTR_W'(DEPTH - 1)) ? '0 : head + PTR_W'(1);
        else         hold <= in_byte;
      end
      count      <= count_nx;
      data_ready <= (count_nx != '0);
      if (accept && push_break)          break_flag <= 1'b1;
      else if (pop && count_nx == '0)    break_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int CT_W = 12,
  localparam int TW  = CT_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cancel,
  input  logic            reload,
  input  logic            clr,
  input  logic            nonempty,
  input  logic [CT_W-1:0] char_time,
  output logic            pend
);
  logic [TW-1:0] cnt;
  logic          armed, expire;

  always_comb expire = armed && (cnt <= TW'(1)) && !reload && nonempty;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      cnt   <= '0;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (reload) begin
        cnt   <= {char_time, 2'b00};
        armed <= 1'b1;
      end else if (armed) begin
        if (cnt <= TW'(1)) armed <= 1'b0;
        else               cnt   <= cnt - TW'(1);
      end
      if (clr)         pend <= 1'b0;
      else if (expire) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CT_W  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [DW-1:0]    push_data,
  input  logic             push_break,
  input  logic             pop,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic [CT_W-1:0]  char_time,
  output logic [DW-1:0]    rd_data,
  output logic [CNT_W-1:0] count,
  output logic             data_ready,
  output logic             break_flag,
  output logic [CNT_W-1:0] trig_level,
  output logic [7:0]       ctl_value,
  output logic             tx_flush,
  output logic             timeout_pend,
  output logic             overrun
);
  logic rx_clr, accept, pop_left, fifo_on;

  rxq_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_value), .trig_q(trig_level), .rx_clr(rx_clr),
    .tx_flush_q(tx_flush)
  );

  assign fifo_on = ctl_value[0];

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .flush(rx_clr),
    .push_valid(push_valid), .push_data(push_data), .push_break(push_break),
    .pop(pop), .rd_data(rd_data), .count(count), .data_ready(data_ready),
    .break_flag(break_flag), .overrun(overrun), .accept(accept),
    .pop_left(pop_left)
  );

  rxq_timeout #(.CT_W(CT_W)) u_tmo (
    .clk(clk), .rst(rst),
    .cancel(rx_clr || !fifo_on),
    .reload(fifo_on && (accept || pop_left)),
    .clr(fifo_on && pop),
    .nonempty(count != '0),
    .char_time(char_time),
    .pend(timeout_pend)
  );
endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push_valid,
  input logic             push_break,
  input logic             pop,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic [DW-1:0]    rd_data,
  input logic [CNT_W-1:0] count,
  input logic             data_ready,
  input logic [CNT_W-1:0] trig_level,
  input logic [7:0]       ctl_value,
  input logic             tx_flush,
  input logic             timeout_pend,
  input logic             overrun
);
  AST_DR_TRACKS_COUNT: assert property (@(posedge clk) disable iff (rst)
    data_ready == (count != '0)); // R1
  AST_STORED_BITS: assert property (@(posedge clk) disable iff (rst)
    (ctl_value & 8'h36) == 8'h00); // R2
  AST_TRIG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    trig_level == CNT_W'(1) || trig_level == CNT_W'(4) || trig_level == CNT_W'(8) || trig_level == CNT_W'(14)); // R3
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata != ctl_value && ctl_wdata[1]) |=> (count == '0 && !timeout_pend && !data_ready)); // R4
  AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[0] != ctl_value[0]) |=> (tx_flush && count == '0)); // R5
  AST_SAME_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata == ctl_value) |=> (!tx_flush && $stable(ctl_value))); // R6
  AST_PEND_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    timeout_pend |-> (count != '0 && ctl_value[0])); // R7
  AST_READ_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
    (pop && ctl_value[0] && !ctl_we) |=> !timeout_pend); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0 && ctl_value[0] && !ctl_we && !push_valid && !push_break) |=> (rd_data == '0 && count == '0)); // R10
  AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (rst)
    overrun |-> ($past(count) == CNT_W'(DEPTH) || ($past(count) == CNT_W'(1) && !$past(ctl_value[0])))); // R11
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl_value[0] |-> count <= CNT_W'(1)); // R12
endmodule

bind rxq_buffer rxq_buffer_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .push_valid(push_valid), .push_break(push_break),
  .pop(pop), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rd_data(rd_data),
  .count(count), .data_ready(data_ready), .trig_level(trig_level),
  .ctl_value(ctl_value), .tx_flush(tx_flush), .timeout_pend(timeout_pend),
  .overrun(overrun)
);

// File: tb/rxq_buffer_bench.sv
module rxq_buffer_bench;
  localparam int DEPTH = 16;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0, push_break = 1'b0, pop = 1'b0, ctl_we = 1'b0;
  logic [7:0] push_data = '0, ctl_wdata = '0;
  logic [11:0] char_time = 12'd50;
  logic [7:0] rd_data, ctl_value;
  logic [CNT_W-1:0] count, trig_level;
  logic data_ready, break_flag, tx_flush, timeout_pend, overrun;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxq_buffer u_rxq_buffer (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .push_break(push_break), .pop(pop), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .char_time(char_time), .rd_data(rd_data), .count(count),
    .data_ready(data_ready), .break_flag(break_flag), .trig_level(trig_level),
    .ctl_value(ctl_value), .tx_flush(tx_flush), .timeout_pend(timeout_pend),
    .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_push(input logic [7:0] d, input bit brk);
    push_valid = !brk; push_break = brk; push_data = d;
    tick();
    push_valid = 0; push_break = 0;
  endtask

  task automatic do_pop(output logic [7:0] v);
    pop = 1; tick(); pop = 0; v = rd_data;
  endtask

  task automatic do_ctl(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
  endtask

  function automatic int dec(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int exp_ctl, exp_trig, exp_tx;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 R3 reset state
    chk("R1 count reset", count, 0);
    chk("R1 dr reset", data_ready, 0);
    chk("R1 ctl reset", ctl_value, 0);
    chk("R3 trig reset", trig_level, 1);
    chk("R1 pend reset", timeout_pend, 0);

    // R2 R3 R4 R5 R6 exhaustive control write sweep
    exp_ctl = 0; exp_trig = 1;
    for (int w = 0; w < 256; w++) begin
      exp_tx = (w != exp_ctl) && (w[2] || (w[0] != exp_ctl[0]));
      if (w != exp_ctl) begin
        exp_ctl = w & 8'hC9;
        if (w[0]) exp_trig = dec(w >> 6);
      end
      do_ctl(8'(w));
      chk("R2 stored mask", ctl_value, exp_ctl);
      chk("R3 trig decode", trig_level, exp_trig);
      chk("R4 R5 R6 tx_flush pulse", tx_flush, exp_tx);
    end
    tick();
    chk("R4 tx_flush one cycle", tx_flush, 0);
    do_ctl(8'h01);
    chk("R2 queued mode", ctl_value, 8'h01);

    // R1 order and fill, R11 overrun
    for (int i = 0; i < DEPTH; i++) begin
      do_push(8'(i * 17 + 3), 0);
      chk("R1 count fill", count, i + 1);
    end
    chk("R1 dr full", data_ready, 1);
    do_push(8'hEE, 0);
    chk("R11 overrun pulse", overrun, 1);
    chk("R11 count held", count, DEPTH);
    tick();
    chk("R11 overrun one cycle", overrun, 0);
    // R11 push and pop together on full
    push_valid = 1; push_data = 8'h77; pop = 1;
    tick();
    push_valid = 0; pop = 0;
    chk("R11 same-cycle count", count, DEPTH);
    chk("R11 same-cycle no overrun", overrun, 0);
    chk("R13 same-cycle read", rd_data, 3);
    for (int i = 1; i < DEPTH; i++) begin
      do_pop(v);
      chk("R13 R1 order", v, (i * 17 + 3) & 8'hFF);
    end
    do_pop(v);
    chk("R11 late byte", v, 8'h77);
    chk("R1 empty count", count, 0);
    chk("R1 empty dr", data_ready, 0);
    do_pop(v);
    chk("R10 empty read data", v, 0);
    chk("R10 empty read count", count, 0);

    // R9 break
    do_push(8'h55, 0);
    do_push(8'h99, 1);
    chk("R9 break flag", break_flag, 1);
    chk("R9 break count", count, 2);
    do_pop(v);
    chk("R9 first byte", v, 8'h55);
    chk("R9 break kept", break_flag, 1);
    do_pop(v);
    chk("R9 zero byte", v, 0);
    chk("R9 break cleared", break_flag, 0);
    chk("R9 dr cleared", data_ready, 0);

    // R7 R8 timeout
    char_time = 12'd3;
    tick();
    do_push(8'h11, 0);
    repeat (11) tick();
    chk("R7 pend not yet", timeout_pend, 0);
    tick();
    chk("R7 pend at 4 chars", timeout_pend, 1);
    do_pop(v);
    chk("R8 read clears pend", timeout_pend, 0);
    repeat (20) tick();
    chk("R7 no pend when empty", timeout_pend, 0);
    do_push(8'h21, 0);
    do_push(8'h22, 0);
    repeat (6) tick();
    do_pop(v);
    repeat (11) tick();
    chk("R7 restart by read", timeout_pend, 0);
    tick();
    chk("R7 pend after read restart", timeout_pend, 1);
    do_pop(v);
    chk("R8 pend cleared", timeout_pend, 0);

    // R6 same value, R4 flush with pending timeout
    do_push(8'h31, 0);
    do_push(8'h32, 0);
    do_ctl(8'h01);
    chk("R6 same write keeps count", count, 2);
    chk("R6 same write no tx", tx_flush, 0);
    repeat (12) tick();
    chk("R7 pend before flush", timeout_pend, 1);
    do_ctl(8'h03);
    chk("R4 flush count", count, 0);
    chk("R4 flush pend", timeout_pend, 0);
    chk("R4 flush dr", data_ready, 0);
    chk("R4 stored after flush", ctl_value, 8'h01);

    // R5 toggle
    do_push(8'h41, 0);
    do_push(8'h42, 0);
    do_push(8'h43, 0);
    do_ctl(8'h00);
    chk("R5 toggle count", count, 0);
    chk("R5 toggle tx", tx_flush, 1);

    // R12 single-byte mode
    do_push(8'hA1, 0);
    chk("R12 count one", count, 1);
    chk("R12 dr", data_ready, 1);
    do_push(8'hB2, 0);
    chk("R12 overrun", overrun, 1);
    chk("R12 count stays", count, 1);
    do_pop(v);
    chk("R12 R13 held byte", v, 8'hA1);
    chk("R12 dr cleared", data_ready, 0);
    do_push(8'h00, 1);
    chk("R12 R9 break", break_flag, 1);
    repeat (20) tick();
    chk("R7 no pend single mode", timeout_pend, 0);
    do_pop(v);
    chk("R12 break read", v, 0);
    chk("R12 break cleared", break_flag, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule